// File: doc/BRIEF.md
# Sensor Fault Status Controller

This block drives one fault status line for a sensor front end, and it also watches for a hardware reset request. A reset is requested by holding the active-low reset pin low while the serial clock pin is held high. Both levels must stay in place without a break for a programmed interval. When this happens the block emits a one-cycle internal reset pulse and restarts its power-up sequence.

The power-up sequence has three named states. `SEQ_HIZ` is the high-impedance window, in which the status output enable is low. The `HIZ_DONE` transition leads to `SEQ_STAB`, the stabilization window, in which the status line is driven high and cannot be cleared. The `STAB_DONE` transition leads to `SEQ_RUN`, the normal operating state. A `RESTART` transition leads from any state back to `SEQ_HIZ` on the internal reset pulse. The power-on reset also places the block in `SEQ_HIZ`.

In `SEQ_RUN` the status line is sticky. It is set by any of the three fault flags (parity, over-temperature, clock frequency). The host clears it with a rising edge on the clear pin. Because the sequence leaves the status high, the host is also told that a reset and initialization took place. All intervals are given in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `sfs_status_ctrl`

## Requirements
- R1: The internal reset pulse `int_rst` is produced when `rst_req_n`=0 and `sclk_pin`=1 are both presented for HOLD_CYC consecutive clock cycles, where HOLD_CYC = CLK_KHZ*HOLD_US/1000, truncated. One cycle fewer produces no pulse.
- R2: If either pin leaves its required level for even one cycle, the hold count restarts from zero. Two HOLD_CYC-1 holds separated by one broken cycle produce no pulse.
- R3: `int_rst` is high for exactly one cycle. A hold kept up far beyond HOLD_CYC yields a single pulse, and a new pulse needs the condition to be released first.
- R4: `status_oe` is 0 while `por_n` is asserted. It is also 0 from the cycle after `int_rst`, and it stays 0 for HIZ_CYC = CLK_KHZ*HIZ_US/1000 cycles in `SEQ_HIZ`.
- R5: When `status_oe` rises, `status_o` is 1. For the next STAB_CYC = CLK_KHZ*STAB_US/1000 cycles a clear edge is ignored and the status stays 1 into `SEQ_RUN`. A clear-pin rise two cycles before the end of `SEQ_STAB` is still ignored; one cycle later it takes effect.
- R6: In `SEQ_RUN`, a 1 on any of `flt_parity`, `flt_overtemp` or `flt_clkfreq` sets `status_o` at the next clock edge.
- R7: In `SEQ_RUN`, `status_o` stays 1 until `clr_pin` goes from 0 to 1. The pin passes through a two-flop synchronizer and an edge detector, so the status reads 0 three clock edges after the rise. The status never falls outside `SEQ_RUN`.
- R8: If a fault flag is 1 at the edge where a clear is applied, `status_o` stays 1.
- R9: A high `rst_req_n` (its inactive, pulled-up level) or a low `sclk_pin` never produces `int_rst`, however long either is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req_n | input | 1 | Reset request pin, active low, inactive when high |
| sclk_pin | input | 1 | Serial clock pin, must be high for a reset request |
| clr_pin | input | 1 | Status clear pin, acts on its rising edge |
| flt_parity | input | 1 | Internal parity fault flag |
| flt_overtemp | input | 1 | Over-temperature fault flag |
| flt_clkfreq | input | 1 | Internal clock frequency fault flag |
| status_o | output | 1 | Status value for the pad |
| status_oe | output | 1 | Status pad output enable, 0 in the high-impedance window |
| int_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The assertions assume that the fault flags are already synchronous to `clk`, and that pin changes come from the synchronizers, so that a flag seen in `SEQ_RUN` is a real request. The bench drives every input on the falling edge. It raises the fault flags in `SEQ_RUN` only during the random phase, and it keeps the reset pin at its inactive level in that phase, so that no random sequence restart breaks the sticky-status model. Holds of the reset pins are applied only in directed cases, with exact lengths around HOLD_CYC.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        SEQ_HIZ  = 2'd0,
        SEQ_STAB = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

    localparam int NUM_FAULTS = 3;

    // converts a duration in microseconds to clock cycles, at least one
    function automatic int us_to_cycles(input int clk_khz, input int dur_us);
        int cyc;
        cyc = (clk_khz * dur_us) / 1000;
        return (cyc < 1) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
    parameter int          WIDTH     = 1,
    parameter logic [31:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RESET_VAL[b];
                sync_q <= RESET_VAL[b];
            end else begin
                meta_q <= d[b];
                sync_q <= meta_q;
            end
        end

        assign q[b] = sync_q;
    end

endmodule

// File: rtl/sfs_hold_detect.sv
module sfs_hold_detect #(
    parameter int HOLD_CYC = 128000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_s,
    input  logic sclk_s,
    output logic pulse_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic          held;
    logic [CW-1:0] cnt_q;
    logic          fired_q;
    logic          pulse_q;

    assign held = !req_n_s && sclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else if (!held) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else if (fired_q) begin
            pulse_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            fired_q <= 1'b1;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/sfs_seq_fsm.sv
module sfs_seq_fsm
    import sfs_pkg::*;
#(
    parameter int HIZ_CYC  = 200000,
    parameter int STAB_CYC = 750000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    output seq_state_t state_o,
    output logic       drive_en,
    output logic       init_busy,
    output logic       clear_allow
);

    localparam int MAX_CYC = (HIZ_CYC > STAB_CYC) ? HIZ_CYC : STAB_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] HIZ_LAST  = TW'(HIZ_CYC - 1);
    localparam logic [TW-1:0] STAB_LAST = TW'(STAB_CYC - 1);

    seq_state_t    state_q, state_n;
    logic [TW-1:0] tmr_q, tmr_n;

    // next state: HIZ_DONE, STAB_DONE, RESTART
    always_comb begin
        state_n = state_q;
        tmr_n   = tmr_q + 1'b1;
        unique case (state_q)
            SEQ_HIZ: begin
                if (tmr_q == HIZ_LAST) begin
                    state_n = SEQ_STAB;
                    tmr_n   = '0;
                end
            end
            SEQ_STAB: begin
                if (tmr_q == STAB_LAST) begin
                    state_n = SEQ_RUN;
                    tmr_n   = '0;
                end
            end
            SEQ_RUN: begin
                tmr_n = '0;
            end
            default: begin
                state_n = SEQ_HIZ;
                tmr_n   = '0;
            end
        endcase
        if (restart) begin
            state_n = SEQ_HIZ;
            tmr_n   = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HIZ;
            tmr_q   <= '0;
        end else begin
            state_q <= state_n;
            tmr_q   <= tmr_n;
        end
    end

    // outputs
    always_comb begin
        drive_en    = 1'b0;
        init_busy   = 1'b1;
        clear_allow = 1'b0;
        unique case (state_q)
            SEQ_HIZ: begin
                drive_en = 1'b0;
            end
            SEQ_STAB: begin
                drive_en = 1'b1;
            end
            SEQ_RUN: begin
                drive_en    = 1'b1;
                init_busy   = 1'b0;
                clear_allow = 1'b1;
            end
            default: begin
                drive_en = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sfs_status_reg.sv
module sfs_status_reg #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_busy,
    input  logic          clear_allow,
    input  logic          clr_s,
    input  logic [NF-1:0] faults,
    output logic          status_o
);

    logic clr_prev_q;
    logic clr_rise;
    logic status_q;

    assign clr_rise = clr_s && !clr_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_prev_q <= 1'b0;
            status_q   <= 1'b1;
        end else begin
            clr_prev_q <= clr_s;
            if (init_busy) begin
                status_q <= 1'b1;
            end else begin
                status_q <= (status_q && !(clr_rise && clear_allow)) || (|faults);
            end
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/sfs_status_ctrl.sv
module sfs_status_ctrl
    import sfs_pkg::*;
#(
    parameter int CLK_KHZ = 250000,
    parameter int HOLD_US = 512,
    parameter int HIZ_US  = 800,
    parameter int STAB_US = 3000
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_req_n,
    input  logic sclk_pin,
    input  logic clr_pin,
    input  logic flt_parity,
    input  logic flt_overtemp,
    input  logic flt_clkfreq,
    output logic status_o,
    output logic status_oe,
    output logic int_rst
);

    localparam int HOLD_CYC = us_to_cycles(CLK_KHZ, HOLD_US);
    localparam int HIZ_CYC  = us_to_cycles(CLK_KHZ, HIZ_US);
    localparam int STAB_CYC = us_to_cycles(CLK_KHZ, STAB_US);

    logic [2:0]            pins_s;
    logic [NUM_FAULTS-1:0] fault_vec;
    seq_state_t            seq_state;
    logic                  init_busy;
    logic                  clear_allow;

    assign fault_vec = {flt_clkfreq, flt_overtemp, flt_parity};

    // bit 2: reset request (idles high), bit 1: serial clock, bit 0: clear
    sfs_sync #(
        .WIDTH     (3),
        .RESET_VAL (32'h4)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({rst_req_n, sclk_pin, clr_pin}),
        .q     (pins_s)
    );

    sfs_hold_detect #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (por_n),
        .req_n_s (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .pulse_o (int_rst)
    );

    sfs_seq_fsm #(
        .HIZ_CYC  (HIZ_CYC),
        .STAB_CYC (STAB_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (por_n),
        .restart     (int_rst),
        .state_o     (seq_state),
        .drive_en    (status_oe),
        .init_busy   (init_busy),
        .clear_allow (clear_allow)
    );

    sfs_status_reg #(
        .NF (NUM_FAULTS)
    ) u_status (
        .clk         (clk),
        .rst_n       (por_n),
        .init_busy   (init_busy),
        .clear_allow (clear_allow),
        .clr_s       (pins_s[0]),
        .faults      (fault_vec),
        .status_o    (status_o)
    );

endmodule

// File: rtl/sfs_status_chk.sv
module sfs_status_chk
    import sfs_pkg::*;
(
    input logic                  clk,
    input logic                  por_n,
    input logic                  int_rst,
    input logic                  status_o,
    input logic                  status_oe,
    input logic [NUM_FAULTS-1:0] faults,
    input seq_state_t            seq_state
);

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |=> !int_rst);

    // R4
    hiz_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |=> (!status_oe && seq_state == SEQ_HIZ));

    // R5
    release_high_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(status_oe) |-> status_o);

    // R5
    stab_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == SEQ_STAB) |-> (status_o && status_oe));

    // R6
    fault_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == SEQ_RUN && (|faults)) |=> status_o);

    // R7
    clear_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(status_o) |-> ($past(seq_state) == SEQ_RUN && !(|$past(faults))));

endmodule

bind sfs_status_ctrl sfs_status_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .int_rst   (int_rst),
    .status_o  (status_o),
    .status_oe (status_oe),
    .faults    (fault_vec),
    .seq_state (seq_state)
);

// File: tb/sfs_status_ctrl_tb.sv
`timescale 1ns/1ps
module sfs_status_ctrl_tb;

    localparam int CLK_KHZ = 100;
    localparam int HOLD_US = 512;
    localparam int HIZ_US  = 800;
    localparam int STAB_US = 3000;
    localparam int HOLD_N  = (CLK_KHZ * HOLD_US) / 1000;
    localparam int HIZ_N   = (CLK_KHZ * HIZ_US) / 1000;
    localparam int STAB_N  = (CLK_KHZ * STAB_US) / 1000;

    logic clk = 1'b0;
    logic por_n, rst_req_n, sclk_pin, clr_pin;
    logic flt_parity, flt_overtemp, flt_clkfreq;
    logic status_o, status_oe, int_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sfs_status_ctrl #(
        .CLK_KHZ (CLK_KHZ),
        .HOLD_US (HOLD_US),
        .HIZ_US  (HIZ_US),
        .STAB_US (STAB_US)
    ) u_dut (
        .clk          (clk),
        .por_n        (por_n),
        .rst_req_n    (rst_req_n),
        .sclk_pin     (sclk_pin),
        .clr_pin      (clr_pin),
        .flt_parity   (flt_parity),
        .flt_overtemp (flt_overtemp),
        .flt_clkfreq  (flt_clkfreq),
        .status_o     (status_o),
        .status_oe    (status_oe),
        .int_rst      (int_rst)
    );

    function automatic logic next_status(input logic s, input logic c2,
                                         input logic c3, input logic anyf);
        return (s && !(c2 && !c3)) || anyf;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // holds the reset pin low with the given serial clock level, counts pulses
    task automatic hold_count(input int n, input logic sclk_lvl, output int pulses);
        pulses    = 0;
        rst_req_n = 1'b0;
        sclk_pin  = sclk_lvl;
        for (int i = 1; i <= n + 8; i++) begin
            @(negedge clk);
            if (i == n) begin
                rst_req_n = 1'b1;
                sclk_pin  = 1'b0;
            end
            if (int_rst) pulses++;
        end
    endtask

    // full reset request, ends at the first sample with status_oe high
    task automatic do_reset();
        bit seen = 0;
        rst_req_n = 1'b0;
        sclk_pin  = 1'b1;
        for (int i = 1; i <= HOLD_N + 6 && !seen; i++) begin
            @(negedge clk);
            if (i == HOLD_N) begin
                rst_req_n = 1'b1;
                sclk_pin  = 1'b0;
            end
            if (int_rst) seen = 1;
        end
        rst_req_n = 1'b1;
        sclk_pin  = 1'b0;
        check_bit("R1 pulse after full hold", seen, 1'b1);
        @(negedge clk);
        check_bit("R4 oe low after pulse", status_oe, 1'b0);
        wait_n(HIZ_N - 1);
        check_bit("R4 oe low at end of window", status_oe, 1'b0);
        @(negedge clk);
        check_bit("R5 oe high after window", status_oe, 1'b1);
        check_bit("R5 status high after window", status_o, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int p;
        logic model, c0, c1, c2, c3;
        void'($urandom(32'd20240611));
        por_n = 1'b0;
        rst_req_n = 1'b1; sclk_pin = 1'b0; clr_pin = 1'b0;
        flt_parity = 1'b0; flt_overtemp = 1'b0; flt_clkfreq = 1'b0;
        wait_n(3);
        check_bit("R4 oe low in por", status_oe, 1'b0);
        check_bit("R3 no pulse in por", int_rst, 1'b0);
        por_n = 1'b1;
        wait_n(HIZ_N - 1);
        check_bit("R4 oe low through window", status_oe, 1'b0);
        @(negedge clk);
        check_bit("R5 oe rises after window", status_oe, 1'b1);
        check_bit("R5 status high on release", status_o, 1'b1);
        wait_n(STAB_N + 4);
        check_bit("R5 status still set in run", status_o, 1'b1);

        // R7 exact clear latency
        clr_pin = 1'b1;
        wait_n(2);
        check_bit("R7 status before edge reaches", status_o, 1'b1);
        @(negedge clk);
        check_bit("R7 status cleared third edge", status_o, 1'b0);
        clr_pin = 1'b0;
        wait_n(4);

        // R6 each fault flag, R8 clear blocked by fault
        flt_parity = 1'b1;
        @(negedge clk);
        check_bit("R6 parity sets status", status_o, 1'b1);
        clr_pin = 1'b1;
        wait_n(5);
        check_bit("R8 clear with fault present", status_o, 1'b1);
        flt_parity = 1'b0;
        clr_pin = 1'b0;
        wait_n(3);
        clr_pin = 1'b1;
        wait_n(5);
        check_bit("R7 clear without fault", status_o, 1'b0);
        clr_pin = 1'b0;
        flt_overtemp = 1'b1;
        @(negedge clk);
        flt_overtemp = 1'b0;
        check_bit("R6 overtemp sets status", status_o, 1'b1);
        wait_n(3);
        check_bit("R7 status sticky after fault drops", status_o, 1'b1);
        clr_pin = 1'b1;
        wait_n(5);
        clr_pin = 1'b0;
        check_bit("R7 clear after overtemp", status_o, 1'b0);
        flt_clkfreq = 1'b1;
        @(negedge clk);
        flt_clkfreq = 1'b0;
        check_bit("R6 clkfreq sets status", status_o, 1'b1);
        clr_pin = 1'b1;
        wait_n(5);
        clr_pin = 1'b0;
        wait_n(3);

        // random phase, R6 R7 R8
        c0 = 1'b0; c1 = 1'b0; c2 = 1'b0; c3 = 1'b0;
        model = status_o;
        for (int i = 0; i < 3000; i++) begin
            logic nc;
            nc = (($urandom % 4) == 0) ? ~clr_pin : clr_pin;
            clr_pin      = nc;
            flt_parity   = (($urandom % 24) == 0);
            flt_overtemp = (($urandom % 24) == 0);
            flt_clkfreq  = (($urandom % 24) == 0);
            c3 = c2; c2 = c1; c1 = c0; c0 = nc;
            model = next_status(model, c2, c3, flt_parity | flt_overtemp | flt_clkfreq);
            @(negedge clk);
            check_bit("R6/R8 random status (R7)", status_o, model);
        end
        flt_parity = 1'b0; flt_overtemp = 1'b0; flt_clkfreq = 1'b0;
        clr_pin = 1'b0;
        wait_n(4);

        // hold detection
        hold_count(HOLD_N - 1, 1'b1, p);
        check_int("R1 short hold no pulse", p, 0);
        rst_req_n = 1'b0; sclk_pin = 1'b1;
        wait_n(HOLD_N - 1);
        sclk_pin = 1'b0;
        @(negedge clk);
        hold_count(HOLD_N - 1, 1'b1, p);
        check_int("R2 broken hold no pulse", p, 0);
        hold_count(HOLD_N + 5, 1'b0, p);
        check_int("R9 sclk low no pulse", p, 0);
        rst_req_n = 1'b1; sclk_pin = 1'b1;
        p = 0;
        for (int i = 0; i < HOLD_N + 5; i++) begin
            @(negedge clk);
            if (int_rst) p++;
        end
        sclk_pin = 1'b0;
        check_int("R9 reset pin idle no pulse", p, 0);

        // R5 stabilization boundary, ignored case
        do_reset();
        wait_n(STAB_N - 3);
        clr_pin = 1'b1;
        wait_n(6);
        check_bit("R5 late stab clear ignored", status_o, 1'b1);
        clr_pin = 1'b0;
        wait_n(8);
        check_bit("R5 status kept into run", status_o, 1'b1);

        // R3 long hold gives one pulse
        hold_count(2 * HOLD_N + 4, 1'b1, p);
        check_int("R3 single pulse per hold", p, 1);
        wait_n(4);

        // R5 boundary, first clear that counts
        do_reset();
        wait_n(STAB_N - 2);
        clr_pin = 1'b1;
        wait_n(6);
        check_bit("R5 first run clear takes effect", status_o, 1'b0);
        clr_pin = 1'b0;
        wait_n(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule